// File: doc/BRIEF.md
# Nine-Bit Message Transmit Framer

This block sits between a message producer and a UART transmitter that sends 9-bit characters. The producer pushes bytes over a valid/ready handshake and flags the final byte of each message. The framer keeps them in a circular store and hands them to the transmitter one at a time. The first byte of every message goes out with the ninth bit set, which lets receivers on a shared line spot the start of a message. Every later byte of the same message goes out with the ninth bit clear.

Most UARTs apply the ninth-bit setting to whatever is in the shift path at that moment. For that reason the framer changes its ninth-bit control only when the transmitter reports that it has fully drained. After the change it loads the next byte. A message becomes visible to the transmit side only once its last byte has been accepted, so a half-written message is never started on the line. A message longer than the configured maximum is thrown away whole. A room indication tells the producer when a message of maximum size is sure to fit.

The transmitter contract is as follows. The transmitter samples `tx_load` on a rising edge. From that same edge it reports `tx_full` high for its single holding stage. `tx_idle` is high only while both the holding stage and the shifter are empty. The ninth bit used for each character is the value of `tx_nine` when that character enters the shifter. `DEPTH` must be a power of two and `MAX_MSG` must not exceed `DEPTH`.

Top module: `nine_bit_tx_framer`

## Requirements
- R1: The first byte of every accepted message is transmitted with ninth bit 1 and every later byte of it with ninth bit 0. A message starts at the first byte accepted after reset or after a byte accepted with `wr_last` = 1.
- R2: `tx_nine` changes only in a cycle whose previous cycle had `tx_idle` = 1 and `tx_load` = 0, and never in the same cycle as a load strobe.
- R3: `tx_load` is never high when `tx_full` was high at the edge that raised it, and is never high in two consecutive cycles.
- R4: After reset `tx_load` = 0, `tx_nine` = 0, `room_ok` = 1 and `wr_ready` = 1. The last-applied ninth-bit value is marked unknown, so the first byte always passes through an explicit ninth-bit setup.
- R5: `room_ok` is 1 exactly when `DEPTH` minus the stored byte count is at least `MAX_MSG`. The stored count covers committed bytes not yet loaded plus the stored bytes of the message in progress. A byte leaves the store in the cycle in which its `tx_load` is high.
- R6: At a message start `wr_ready` equals `room_ok`. Once a message has begun, `wr_ready` stays 1 until its last byte is accepted.
- R7: No byte of a message is loaded into the transmitter before the last byte of that message has been accepted.
- R8: A message of more than `MAX_MSG` bytes is discarded completely: none of its bytes is transmitted and its space is released when its last byte is accepted. Messages before and after it are unaffected.
- R9: While no committed byte is waiting, `tx_load` stays 0 and `tx_nine` holds its value.
- R10: Messages are transmitted in the order they were accepted, with their bytes in order, also when the store pointers wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Producer offers a byte |
| wr_data | input | DATA_W | Byte offered by the producer |
| wr_last | input | 1 | Offered byte closes its message |
| wr_ready | output | 1 | Byte is accepted on this edge when `wr_valid` is high |
| room_ok | output | 1 | Free space holds a message of maximum size |
| tx_data | output | DATA_W | Byte for the transmitter holding stage |
| tx_load | output | 1 | One-cycle strobe: transmitter takes `tx_data` |
| tx_nine | output | 1 | Ninth-bit control applied by the transmitter |
| tx_full | input | 1 | Transmitter holding stage occupied |
| tx_idle | input | 1 | Transmitter holding stage and shifter both empty |

## Verification
Each kind of internal fault shows up at the ports in its own way. If the commit pointer or the pending count goes wrong, `room_ok` or `wr_ready` differs from the occupancy model in the very next cycle, or a byte appears on the line before its message closed. A stale or wrongly invalidated ninth-bit state shows up as a character carrying the wrong ninth bit, or as a `tx_nine` change while the transmitter is busy. The second case is flagged in the cycle of the change, the first as soon as the character reaches the modelled shifter. A read-pointer or store fault shows up as a wrong byte or a wrong order, caught at the first mismatching character in the stream.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

  // Decision taken by the transmit sequencer in one cycle
  typedef enum logic [1:0] {
    ACT_WAIT  = 2'd0,
    ACT_SETUP = 2'd1,
    ACT_SEND  = 2'd2
  } tx_act_e;

endpackage

// File: rtl/nbf_msg_writer.sv
module nbf_msg_writer #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 32,
  parameter int MAX_MSG = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int CW = $clog2(MAX_MSG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              wr_ready,
  output logic              room_ok,
  input  logic [PW-1:0]     rd_tail,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic              mem_wmark,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [PW-1:0]     head_commit
);

  logic [PW-1:0] spec_q;   // write position, includes the open message
  logic [PW-1:0] head_q;   // end of the last closed message
  logic [CW-1:0] pend_q;   // bytes stored for the open message
  logic          in_msg_q;
  logic          over_q;   // open message has exceeded MAX_MSG

  logic [PW-1:0] used;
  logic          accept;
  logic          fits;

  assign used     = spec_q - rd_tail;
  assign room_ok  = (PW'(DEPTH) - used) >= PW'(MAX_MSG);
  assign wr_ready = in_msg_q | room_ok;
  assign accept   = wr_valid & wr_ready;
  assign fits     = pend_q < CW'(MAX_MSG);

  assign mem_we      = accept & fits;
  assign mem_waddr   = spec_q[AW-1:0];
  assign mem_wmark   = (pend_q == '0);
  assign mem_wdata   = wr_data;
  assign head_commit = head_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_q   <= '0;
      head_q   <= '0;
      pend_q   <= '0;
      in_msg_q <= 1'b0;
      over_q   <= 1'b0;
    end else if (accept) begin
      if (wr_last) begin
        in_msg_q <= 1'b0;
        pend_q   <= '0;
        over_q   <= 1'b0;
        if (over_q || !fits) begin
          spec_q <= head_q;
        end else begin
          spec_q <= spec_q + PW'(1);
          head_q <= spec_q + PW'(1);
        end
      end else begin
        in_msg_q <= 1'b1;
        if (fits) begin
          spec_q <= spec_q + PW'(1);
          pend_q <= pend_q + CW'(1);
        end else begin
          over_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/nbf_store.sv
module nbf_store #(
  parameter int W     = 9,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // Simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/nbf_tx_seq.sv
module nbf_tx_seq
  import nbf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PW-1:0]     head_commit,
  input  logic              rd_mark,
  input  logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     rd_addr,
  output logic [PW-1:0]     tail,
  input  logic              tx_full,
  input  logic              tx_idle,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_nine
);

  logic [PW-1:0] head_d;    // commit pointer, one cycle late to cover read latency
  logic [PW-1:0] tail_q;
  logic [PW-1:0] tail_nx;
  logic          nine_vld;  // tx_nine reflects a setting already applied
  logic          avail;
  logic          same_nine;
  tx_act_e       act;

  assign avail     = head_d != tail_q;
  assign same_nine = nine_vld & (rd_mark == tx_nine);

  always_comb begin
    act = ACT_WAIT;
    if (avail && !tx_load) begin
      if (same_nine) begin
        if (!tx_full) act = ACT_SEND;
      end else if (tx_idle) begin
        act = ACT_SETUP;
      end
    end
  end

  assign tail_nx = tail_q + PW'(act == ACT_SEND);
  assign rd_addr = tail_nx[AW-1:0];
  assign tail    = tail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_d   <= '0;
      tail_q   <= '0;
      nine_vld <= 1'b0;
      tx_nine  <= 1'b0;
      tx_load  <= 1'b0;
      tx_data  <= '0;
    end else begin
      head_d  <= head_commit;
      tail_q  <= tail_nx;
      tx_load <= (act == ACT_SEND);
      if (act == ACT_SEND) tx_data <= rd_data;
      if (act == ACT_SETUP) begin
        tx_nine  <= rd_mark;
        nine_vld <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/nine_bit_tx_framer.sv
module nine_bit_tx_framer #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 32,
  parameter int MAX_MSG = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int EW = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              wr_ready,
  output logic              room_ok,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_load,
  output logic              tx_nine,
  input  logic              tx_full,
  input  logic              tx_idle
);

  logic              mem_we;
  logic [AW-1:0]     mem_waddr;
  logic              mem_wmark;
  logic [DATA_W-1:0] mem_wdata;
  logic [AW-1:0]     mem_raddr;
  logic [EW-1:0]     mem_rdata;
  logic [PW-1:0]     head_c;
  logic [PW-1:0]     tail_p;

  nbf_msg_writer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_MSG(MAX_MSG)) writer_i (
    .clk         (clk),
    .rst         (rst),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .wr_last     (wr_last),
    .wr_ready    (wr_ready),
    .room_ok     (room_ok),
    .rd_tail     (tail_p),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_wmark   (mem_wmark),
    .mem_wdata   (mem_wdata),
    .head_commit (head_c)
  );

  nbf_store #(.W(EW), .DEPTH(DEPTH)) store_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata ({mem_wmark, mem_wdata}),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  nbf_tx_seq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .head_commit (head_c),
    .rd_mark     (mem_rdata[EW-1]),
    .rd_data     (mem_rdata[DATA_W-1:0]),
    .rd_addr     (mem_raddr),
    .tail        (tail_p),
    .tx_full     (tx_full),
    .tx_idle     (tx_idle),
    .tx_load     (tx_load),
    .tx_data     (tx_data),
    .tx_nine     (tx_nine)
  );

endmodule

// File: rtl/nbf_checker.sv
module nbf_checker #(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          wr_last,
  input logic          room_ok,
  input logic          tx_load,
  input logic          tx_full,
  input logic          tx_idle,
  input logic          tx_nine,
  input logic [PW-1:0] head_commit,
  input logic [PW-1:0] tail
);

  AST_LOAD_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> $past(!tx_full)); // R3

  AST_LOAD_SPACED: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_load); // R3

  AST_NINE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (tx_nine != $past(tx_nine)) |-> ($past(tx_idle) && !$past(tx_load))); // R2

  AST_NINE_NOT_WITH_LOAD: assert property (@(posedge clk) disable iff (rst)
    (tx_nine != $past(tx_nine)) |-> !tx_load); // R2

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (head_commit == tail) |=> !tx_load); // R9

  AST_ROOM_READY: assert property (@(posedge clk) disable iff (rst)
    room_ok |-> wr_ready); // R6

  AST_MID_MSG_READY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_valid && wr_ready && !wr_last)) |-> wr_ready); // R6

endmodule

bind nine_bit_tx_framer nbf_checker #(.PW(PW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_last     (wr_last),
  .room_ok     (room_ok),
  .tx_load     (tx_load),
  .tx_full     (tx_full),
  .tx_idle     (tx_idle),
  .tx_nine     (tx_nine),
  .head_commit (head_c),
  .tail        (tail_p)
);

// File: tb/nine_bit_tx_framer_tb.sv
`timescale 1ns/1ps
module nine_bit_tx_framer_tb_top;

  localparam int DATA_W  = 8;
  localparam int DEPTH   = 32;
  localparam int MAX_MSG = 8;
  localparam int SHIFT   = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_valid = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              wr_last = 1'b0;
  logic              wr_ready;
  logic              room_ok;
  logic [DATA_W-1:0] tx_data;
  logic              tx_load;
  logic              tx_nine;
  logic              tx_full;
  logic              tx_idle;

  always #4 clk = ~clk;

  nine_bit_tx_framer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_MSG(MAX_MSG)) dut_i (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
    .wr_ready(wr_ready), .room_ok(room_ok),
    .tx_data(tx_data), .tx_load(tx_load), .tx_nine(tx_nine),
    .tx_full(tx_full), .tx_idle(tx_idle)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural transmitter ----------------
  logic              u_hold_v = 1'b0;
  logic [DATA_W-1:0] u_hold_d = '0;
  int                u_cnt    = 0;
  bit                u_pause  = 1'b0;
  bit                u_ovr    = 1'b0;
  logic [8:0]        got_q[$];

  assign tx_full = u_hold_v;
  assign tx_idle = !u_hold_v && (u_cnt == 0);

  always @(posedge clk) begin
    bit mv;
    if (rst) begin
      u_hold_v <= 1'b0;
      u_cnt    <= 0;
    end else begin
      mv = u_hold_v && (u_cnt == 0) && !u_pause;
      if (u_cnt != 0) u_cnt <= u_cnt - 1;
      else if (mv) begin
        u_cnt <= SHIFT;
        got_q.push_back({tx_nine, u_hold_d});
      end
      if (tx_load) begin
        if (u_hold_v && !mv) u_ovr <= 1'b1;
        u_hold_v <= 1'b1;
        u_hold_d <= tx_data;
      end else if (mv) begin
        u_hold_v <= 1'b0;
      end
    end
  end

  // ---------------- reference model, compared every cycle ----------------
  int         m_commit = 0, m_loads = 0, m_pend = 0, m_idx = 0;
  bit         m_over = 1'b0;
  logic [8:0] stage_q[$];
  logic [8:0] exp_q[$];
  bit         p_nine = 1'b0, p_idle = 1'b1, p_load = 1'b0;

  always @(negedge clk) begin
    #3;
    if (!rst && !done) begin
      int used;
      bit exp_room;
      if (tx_load) m_loads++;
      chk(!(p_load && tx_load), "R3 back-to-back load", int'(tx_load), 0);
      chk(!u_ovr, "R3 load into full holding stage", int'(u_ovr), 0);
      chk(m_loads <= m_commit, "R7 load before message closed", m_loads, m_commit);
      used     = m_commit - m_loads + m_pend;
      exp_room = (DEPTH - used) >= MAX_MSG;
      chk(room_ok == exp_room, "R5 room_ok", int'(room_ok), int'(exp_room));
      chk(wr_ready == (m_idx != 0 || exp_room), "R6 wr_ready", int'(wr_ready),
          int'(m_idx != 0 || exp_room));
      if (tx_nine != p_nine) begin
        chk(p_idle && !p_load, "R2 ninth bit changed while busy", int'(p_idle), 1);
        chk(!tx_load, "R2 load with ninth-bit change", int'(tx_load), 0);
      end
      while (got_q.size() != 0) begin
        logic [8:0] g;
        g = got_q.pop_front();
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected character", int'(g), -1);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(g[8] == e[8], "R1 ninth bit", int'(g[8]), int'(e[8]));
          chk(g[7:0] == e[7:0], "R10 byte order", int'(g[7:0]), int'(e[7:0]));
        end
      end
      if (wr_valid && wr_ready) begin
        bit st;
        st = m_pend < MAX_MSG;
        if (st) begin
          stage_q.push_back({(m_idx == 0), wr_data});
          m_pend++;
        end else m_over = 1'b1;
        m_idx++;
        if (wr_last) begin
          if (!m_over) begin
            m_commit += m_pend;
            foreach (stage_q[i]) exp_q.push_back(stage_q[i]);
          end
          stage_q.delete();
          m_pend = 0; m_idx = 0; m_over = 1'b0;
        end
      end
      p_nine = tx_nine; p_idle = tx_idle; p_load = tx_load;
    end
  end

  // ---------------- stimulus ----------------
  task automatic put_byte(input logic [7:0] d, input bit last);
    bit ok;
    wr_valid = 1'b1; wr_data = d; wr_last = last;
    do begin
      #2; ok = wr_ready;
      @(negedge clk); #1;
    end while (!ok);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic send_msg(input int len, input int seed, input int gap);
    for (int i = 0; i < len; i++) begin
      put_byte(8'((seed * 7 + i * 13 + 1) & 8'hff), i == len - 1);
      if (gap != 0) idle_cycles(gap);
    end
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0 || got_q.size() != 0 || !tx_idle) idle_cycles(1);
    idle_cycles(3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    #2;
    // R4 reset state
    chk(tx_load == 1'b0, "R4 tx_load after reset", int'(tx_load), 0);
    chk(tx_nine == 1'b0, "R4 tx_nine after reset", int'(tx_nine), 0);
    chk(room_ok == 1'b1, "R4 room_ok after reset", int'(room_ok), 1);
    chk(wr_ready == 1'b1, "R4 wr_ready after reset", int'(wr_ready), 1);
    @(negedge clk); #1;

    // R1 R11-style start: single-byte message, then back-to-back messages
    send_msg(1, 1, 0);
    send_msg(3, 2, 0);
    send_msg(5, 3, 0);
    wait_drain();
    // R9: nothing waiting, no loads and tx_nine steady
    begin
      bit n0;
      n0 = tx_nine;
      idle_cycles(20);
      chk(tx_nine == n0, "R9 tx_nine held while empty", int'(tx_nine), int'(n0));
    end

    // Full-size message with gaps between bytes
    send_msg(MAX_MSG, 4, 2);
    wait_drain();

    // R8 overlong messages dropped, neighbours intact
    send_msg(2, 5, 0);
    send_msg(MAX_MSG + 2, 6, 0);
    send_msg(MAX_MSG + 1, 7, 1);
    send_msg(2, 8, 0);
    wait_drain();
    chk(m_loads == m_commit, "R8 only closed short messages sent", m_loads, m_commit);

    // R5 R6 fill with the transmitter stalled
    u_pause = 1'b1;
    send_msg(MAX_MSG, 9, 0);
    send_msg(MAX_MSG, 10, 0);
    send_msg(MAX_MSG, 11, 0);
    for (int i = 0; i < 3; i++) put_byte(8'(8'h40 + i), 1'b0);
    #2;
    chk(room_ok == 1'b0, "R5 room low mid-message", int'(room_ok), 0);
    chk(wr_ready == 1'b1, "R6 ready held mid-message", int'(wr_ready), 1);
    @(negedge clk); #1;
    for (int i = 3; i < MAX_MSG; i++) put_byte(8'(8'h40 + i), i == MAX_MSG - 1);
    #2;
    chk(room_ok == 1'b0, "R5 room low when store nearly full", int'(room_ok), 0);
    chk(wr_ready == 1'b0, "R6 start refused without room", int'(wr_ready), 0);
    @(negedge clk); #1;
    u_pause = 1'b0;
    send_msg(4, 12, 0);
    wait_drain();

    // R10 many messages across pointer wrap
    for (int k = 0; k < 24; k++) send_msg(1 + ((k * 5 + 3) % MAX_MSG), 20 + k, k % 2);
    wait_drain();
    chk(exp_q.size() == 0, "R10 all messages delivered", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule